// File: doc/BRIEF.md
# Parallel-Load Serializing Line Buffer

This block holds one line of image or print data in a word RAM that a host fills over a 16-bit parallel bus. Words arrive either as plain bus writes or through a DMA handshake, in which the block raises a request and the controller answers with one acknowledge per word. Once the line is loaded, a start command sends the line out on a single serial data pin. Before the data the block can send a programmable run of constant bits, all high or all low.

The serial stream is paced in one of two ways. In internal pacing the system clock is divided by 1, 2, 4, 8 or 16, and a matching clock is driven out for the receiver. In external pacing the receiving peripheral pulses a request line once for every bit it wants. Words are played either in load order, most significant bit first, or as the exact bit-reverse of that stream. A busy flag covers the whole transfer. A one-cycle done pulse and a latched interrupt mark its end.

Top module: `line_serializer`

## Requirements
- R1: The bus has four targets picked by `bus_sel`: 0 is a data word, 1 is the configuration, 2 is the line length in words, and 3 is control. Data words go into the RAM at a write pointer that advances by one per word. A control write with bit 2 set rewinds the pointer to zero and arms a DMA load. A length above the RAM depth is saturated to the depth.
- R2: `dma_req` is high while a DMA load is armed and the word count is below the line length. Each cycle with both `dma_ack` and `dma_req` high stores `bus_wdata` as the next word. `dma_req` is low in the cycle after the final word is accepted.
- R3: When configuration bit 4 is 0 (load order), the stream sends word 0 first and each word most significant bit first.
- R4: When configuration bit 4 is 1 (reverse order), the data part of the stream is the exact reverse of the load-order stream: the last word goes first, least significant bit first.
- R5: Configuration bits 15:8 give a prefix count P. P bits at the level of configuration bit 5 are sent before the data. P = 0 sends no prefix.
- R6: With configuration bit 3 clear, each bit lasts N = 2^S clock cycles, where S is configuration bits 2:0 and any S above 4 counts as 4. Within a bit, counting its cycles from 0, `ser_clk` is high in cycles N/2 and above. With N = 1 it is high throughout.
- R7: With configuration bit 3 set, the output moves to the next bit once per rising edge of `ext_req` seen while busy, and `ser_clk` stays low.
- R8: A control write with bit 0 set starts output and raises `busy` from the next cycle, unless the line length is zero, in which case nothing happens. `busy` falls right after the period of the last data bit.
- R9: `done` is high for exactly the one cycle in which `busy` has just fallen. `intr` rises in that same cycle and stays high until a control write with bit 1 set.
- R10: All bus writes, including configuration changes, are ignored while `busy` is high.
- R11: After reset `busy`, `done`, `intr`, `dma_req`, `ser_clk` and `ser_data` are low. `ser_data` is also low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 2 | Bus target: data, configuration, length, control |
| bus_wdata | input | DATA_W | Bus write data, also the DMA data |
| dma_ack | input | 1 | DMA acknowledge, one word per cycle |
| dma_req | output | 1 | DMA word request |
| ext_req | input | 1 | Peripheral bit request strobe |
| ser_clk | output | 1 | Serial clock output in internal pacing |
| ser_data | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| intr | output | 1 | Latched end-of-transfer interrupt |

## Verification
The bench plays every divider setting in both playback orders, with prefix lengths that include zero and both prefix levels. At every cycle it compares the serial data and the serial clock against a bit list built from the words it wrote. A divider decode that is off by one power shows up at once as a stream running twice as fast or half as fast. A reverse mode that reverses only the word order, or only the bit order, puts wrong bits in the middle of the stream. A prefix counter that wraps sends 256 extra bits when the count is zero. The bench also checks that `dma_req` falls in the cycle right after the final acknowledge, that a configuration write during a transfer leaves the stream intact, that an out-of-range divider code behaves like divide-by-16, and that a start with a zero line length does nothing.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_CFG  = 2'd1;
   localparam logic [1:0] SEL_LEN  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam int CTL_START = 0;
   localparam int CTL_CLR   = 1;
   localparam int CTL_ARM   = 2;

   localparam int SEL_W = 3;

   typedef struct packed {
      logic             pfx_lvl;
      logic             rev;
      logic             ext;
      logic [SEL_W-1:0] div_sel;
   } mode_t;
endpackage

// File: rtl/lsb_store.sv
module lsb_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 320,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/lsb_busif.sv
module lsb_busif
   import lsb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 320,
   parameter int PFX_W  = 8,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LEN_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              dma_ack,
   input  logic              busy,
   output mode_t             mode,
   output logic [PFX_W-1:0]  pfx_len,
   output logic [LEN_W-1:0]  line_len,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic              dma_req,
   output logic              start,
   output logic              irq_clr
);
   logic             open_bus;
   logic             ctrl_wr;
   logic             arm;
   logic             word_we;
   logic             loading;
   logic [LEN_W-1:0] wptr;
   logic [LEN_W:0]   wptr_nx;

   assign open_bus = !busy;
   assign ctrl_wr  = open_bus && bus_wr && (bus_sel == SEL_CTRL);
   assign arm      = ctrl_wr && bus_wdata[CTL_ARM];
   assign start    = ctrl_wr && bus_wdata[CTL_START] && (line_len != '0);
   assign irq_clr  = ctrl_wr && bus_wdata[CTL_CLR];

   assign dma_req  = loading && (wptr < line_len);
   assign word_we  = open_bus && ((bus_wr && bus_sel == SEL_DATA) || (dma_ack && dma_req));
   assign mem_we   = word_we && (wptr < LEN_W'(DEPTH));
   assign mem_waddr = wptr[ADDR_W-1:0];
   assign wptr_nx  = {1'b0, wptr} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         loading <= 1'b0;
      end else if (arm) begin
         wptr    <= '0;
         loading <= 1'b1;
      end else if (word_we) begin
         if (wptr < LEN_W'(DEPTH)) wptr <= wptr_nx[LEN_W-1:0];
         if (wptr_nx >= {1'b0, line_len}) loading <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= '0;
         pfx_len  <= '0;
         line_len <= '0;
      end else if (open_bus && bus_wr) begin
         if (bus_sel == SEL_CFG) begin
            mode.div_sel <= bus_wdata[SEL_W-1:0];
            mode.ext     <= bus_wdata[3];
            mode.rev     <= bus_wdata[4];
            mode.pfx_lvl <= bus_wdata[5];
            pfx_len      <= bus_wdata[8 +: PFX_W];
         end else if (bus_sel == SEL_LEN) begin
            line_len <= (bus_wdata > DATA_W'(DEPTH)) ? LEN_W'(DEPTH) : bus_wdata[LEN_W-1:0];
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_wdata[7:6], bus_wdata[DATA_W-1:8+PFX_W]};
endmodule

// File: rtl/lsb_pacer.sv
module lsb_pacer
   import lsb_pkg::*;
#(
   parameter int EXT_SYNC = 1,
   parameter int MAX_LOG  = 4,
   localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             ext,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             ext_req,
   output logic             tick,
   output logic             ser_clk
);
   logic [SEL_W-1:0] sel_c;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] half;
   logic             req_s;
   logic             req_q;

   always_comb begin
      sel_c = (div_sel > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : div_sel;
      last  = CNT_W'((1 << sel_c) - 1);
      half  = CNT_W'((1 << sel_c) >> 1);
   end

   if (EXT_SYNC != 0) begin : g_sync
      logic [1:0] sync;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync <= '0;
         else        sync <= {sync[0], ext_req};
      end
      assign req_s = sync[1];
   end else begin : g_raw
      assign req_s = ext_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= req_s;
         if (!busy || ext || cnt == last) cnt <= '0;
         else                             cnt <= cnt + 1'b1;
      end
   end

   assign tick    = busy && (ext ? (req_s && !req_q) : (cnt == last));
   assign ser_clk = busy && !ext && (cnt >= half);
endmodule

// File: rtl/lsb_shifter.sv
module lsb_shifter #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 320,
   parameter int PFX_W  = 8,
   localparam int LEN_W = $clog2(DEPTH + 1),
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic              rev,
   input  logic              pfx_lvl,
   input  logic [PFX_W-1:0]  pfx_len,
   input  logic [LEN_W-1:0]  line_len,
   input  logic [DATA_W-1:0] rd_data,
   output logic [LEN_W-1:0]  rd_word,
   output logic              busy,
   output logic              done,
   output logic              finish,
   output logic              ser_data
);
   logic             in_pfx;
   logic [PFX_W-1:0] pfx_left;
   logic [BIT_W-1:0] bidx;
   logic             last_bit;

   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(DATA_W - 1);

   assign last_bit = !in_pfx && (rev ? (rd_word == '0 && bidx == TOP_BIT)
                                     : (rd_word == line_len - 1'b1 && bidx == '0));
   assign finish   = busy && tick && last_bit;
   assign ser_data = busy && (in_pfx ? pfx_lvl : rd_data[bidx]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         in_pfx   <= 1'b0;
         pfx_left <= '0;
         rd_word  <= '0;
         bidx     <= '0;
      end else begin
         done <= finish;
         if (start && !busy) begin
            busy     <= 1'b1;
            in_pfx   <= (pfx_len != '0);
            pfx_left <= pfx_len;
            rd_word  <= rev ? line_len - 1'b1 : '0;
            bidx     <= rev ? '0 : TOP_BIT;
         end else if (busy && tick) begin
            if (in_pfx) begin
               if (pfx_left == PFX_W'(1)) in_pfx <= 1'b0;
               pfx_left <= pfx_left - 1'b1;
            end else if (last_bit) begin
               busy <= 1'b0;
            end else if (rev) begin
               if (bidx == TOP_BIT) begin
                  bidx    <= '0;
                  rd_word <= rd_word - 1'b1;
               end else begin
                  bidx <= bidx + 1'b1;
               end
            end else begin
               if (bidx == '0) begin
                  bidx    <= TOP_BIT;
                  rd_word <= rd_word + 1'b1;
               end else begin
                  bidx <= bidx - 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/line_serializer.sv
module line_serializer
   import lsb_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DEPTH    = 320,
   parameter int PFX_W    = 8,
   parameter int EXT_SYNC = 1,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LEN_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              dma_ack,
   output logic              dma_req,
   input  logic              ext_req,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              busy,
   output logic              done,
   output logic              intr
);
   if (DATA_W < 16 || (1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 16");
   end
   if (PFX_W < 1 || PFX_W > DATA_W - 8) begin : g_bad_pfx
      $error("PFX_W must fit in the configuration word above bit 7");
   end
   if (DEPTH < 2 || DEPTH >= (1 << 16) || LEN_W > DATA_W) begin : g_bad_depth
      $error("DEPTH out of range");
   end

   mode_t             mode;
   logic [PFX_W-1:0]  pfx_len;
   logic [LEN_W-1:0]  line_len;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] rd_data;
   logic [LEN_W-1:0]  rd_word;
   logic              start;
   logic              irq_clr;
   logic              tick;
   logic              finish;

   lsb_busif #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PFX_W(PFX_W)) busif_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .dma_ack(dma_ack), .busy(busy), .mode(mode),
      .pfx_len(pfx_len), .line_len(line_len), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .dma_req(dma_req), .start(start), .irq_clr(irq_clr)
   );

   lsb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(bus_wdata),
      .raddr(rd_word[ADDR_W-1:0]), .rdata(rd_data)
   );

   lsb_pacer #(.EXT_SYNC(EXT_SYNC)) pacer_i (
      .clk(clk), .rst_n(rst_n), .busy(busy), .ext(mode.ext),
      .div_sel(mode.div_sel), .ext_req(ext_req), .tick(tick), .ser_clk(ser_clk)
   );

   lsb_shifter #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PFX_W(PFX_W)) shifter_i (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .rev(mode.rev),
      .pfx_lvl(mode.pfx_lvl), .pfx_len(pfx_len), .line_len(line_len),
      .rd_data(rd_data), .rd_word(rd_word), .busy(busy), .done(done),
      .finish(finish), .ser_data(ser_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       intr <= 1'b0;
      else if (finish)  intr <= 1'b1;
      else if (irq_clr) intr <= 1'b0;
   end

   logic unused_rd;
   assign unused_rd = ^rd_word;
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker
   import lsb_pkg::*;
#(
   parameter int LEN_W = 9,
   parameter int PFX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             intr,
   input logic             dma_req,
   input logic             ser_clk,
   input logic             ser_data,
   input mode_t            mode,
   input logic [PFX_W-1:0] pfx_len,
   input logic [LEN_W-1:0] line_len
);
   // R9
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R9
   intr_set_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> intr);
   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
   // R7
   ext_clk_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && mode.ext) |-> !ser_clk);
   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mode) && $stable(pfx_len) && $stable(line_len)));
   // R2
   dreq_len_chk: assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> (line_len != '0));
   // R11
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!ser_data && !ser_clk));
endmodule

bind line_serializer lsb_checker #(.LEN_W(LEN_W), .PFX_W(PFX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .intr(intr),
   .dma_req(dma_req), .ser_clk(ser_clk), .ser_data(ser_data), .mode(mode),
   .pfx_len(pfx_len), .line_len(line_len)
);

// File: tb/line_serializer_tb_top.sv
module line_serializer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic        dma_ack = 1'b0;
   logic        ext_req = 1'b0;
   logic        dma_req, ser_clk, ser_data, busy, done, intr;

   int checks = 0;
   int errors = 0;
   logic [15:0] words [8];
   int          nwords;

   always #5 clk = ~clk;

   line_serializer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .dma_ack(dma_ack), .dma_req(dma_req),
      .ext_req(ext_req), .ser_clk(ser_clk), .ser_data(ser_data),
      .busy(busy), .done(done), .intr(intr)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         if (errors < 20) $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bw(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   function automatic logic exp_bit(int b, int pfx, logic lvl, logic rev);
      int d;
      if (b < pfx) return lvl;
      d = b - pfx;
      if (!rev) return words[d / 16][15 - (d % 16)];
      return words[nwords - 1 - d / 16][d % 16];
   endfunction

   // R1 plain word loading
   task automatic load_plain(int n);
      nwords = n;
      bw(2'd2, 16'(n));
      bw(2'd3, 16'h0004);
      for (int i = 0; i < n; i++) begin
         words[i] = 16'($urandom);
         bw(2'd0, words[i]);
      end
   endtask

   // R2 DMA loading
   task automatic load_dma(int n);
      nwords = n;
      bw(2'd2, 16'(n));
      bw(2'd3, 16'h0004);
      for (int i = 0; i < n; i++) begin
         chk("R2 dreq high", int'(dma_req), 1);
         words[i] = 16'($urandom);
         dma_ack = 1'b1; bus_wdata = words[i];
         @(negedge clk);
         dma_ack = 1'b0;
      end
      chk("R2 dreq low after last", int'(dma_req), 0);
   endtask

   task automatic run_int(int sel, logic rev, logic lvl, int pfx, bit poke);
      int n, total;
      n = 1 << ((sel > 4) ? 4 : sel);
      total = pfx + nwords * 16;
      bw(2'd1, 16'((pfx << 8) | (int'(lvl) << 5) | (int'(rev) << 4) | sel));
      bw(2'd3, 16'h0001);
      for (int c = 0; c < total * n; c++) begin
         chk(rev ? "R4 data" : "R3 data", int'(ser_data), int'(exp_bit(c / n, pfx, lvl, rev)));
         chk("R6 ser_clk", int'(ser_clk), int'((c % n) >= (n / 2)));
         chk("R8 busy", int'(busy), 1);
         if (poke && c == 2) begin
            bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 16'h0008;  // R10
         end
         if (poke && c == 3) bus_wr = 1'b0;
         @(negedge clk);
      end
      chk("R8 busy low at end", int'(busy), 0);
      chk("R9 done pulse", int'(done), 1);
      chk("R9 intr set", int'(intr), 1);
      @(negedge clk);
      chk("R9 done one cycle", int'(done), 0);
      chk("R9 intr held", int'(intr), 1);
      bw(2'd3, 16'h0002);
      chk("R9 intr cleared", int'(intr), 0);
   endtask

   task automatic run_ext(logic rev, logic lvl, int pfx);
      int total;
      total = pfx + nwords * 16;
      bw(2'd1, 16'((pfx << 8) | (int'(lvl) << 5) | (int'(rev) << 4) | 8));
      bw(2'd3, 16'h0001);
      for (int k = 0; k < total; k++) begin
         chk("R7 data", int'(ser_data), int'(exp_bit(k, pfx, lvl, rev)));
         chk("R7 ser_clk low", int'(ser_clk), 0);
         chk("R7 busy", int'(busy), 1);
         ext_req = 1'b1;
         repeat (2) @(negedge clk);
         ext_req = 1'b0;
         repeat (3) @(negedge clk);
      end
      chk("R7 busy low after last strobe", int'(busy), 0);
      chk("R7 intr", int'(intr), 1);
      bw(2'd3, 16'h0002);
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            chk("watchdog", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", int'(busy), 0);
      chk("R11 done", int'(done), 0);
      chk("R11 intr", int'(intr), 0);
      chk("R11 dreq", int'(dma_req), 0);
      chk("R11 ser_data", int'(ser_data), 0);
      chk("R11 ser_clk", int'(ser_clk), 0);
      // R8 start with zero length is ignored
      bw(2'd3, 16'h0001);
      chk("R8 zero length start", int'(busy), 0);

      for (int sel = 0; sel <= 4; sel++) begin
         for (int r = 0; r < 2; r++) begin
            if (sel == 2) load_dma(4);
            else          load_plain(3);
            // R5 prefix lengths vary, including zero
            run_int(sel, logic'(r), logic'((sel + r) % 2), (sel * 3 + r * 5) % 9, 1'b0);
         end
      end
      // R6 out-of-range code acts as /16, R10 config write during busy
      load_plain(2);
      run_int(7, 1'b0, 1'b1, 4, 1'b1);
      // R5 longer prefix with one word, reverse order
      load_plain(1);
      run_int(1, 1'b1, 1'b1, 20, 1'b0);
      // R7 external pacing in both orders
      load_plain(2);
      run_ext(1'b0, 1'b1, 3);
      run_ext(1'b1, 1'b0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule